// File: doc/BRIEF.md
# Channel Interrupt Vector Responder

This block is the interrupt front end of a sixteen-channel timing peripheral. Each channel can post a service request; requests are held as pending bits, filtered by a per-channel enable, and the lowest-numbered surviving channel is offered for service. The module raises a request line toward the interrupt controller while any enabled channel is pending.

When the system opens an arbitration round, every requesting module places its 4-bit arbitration identifier on a shared wired-OR line, one bit per cycle, most significant bit first. A module that drives 0 while the line reads 1 drops out and stays silent for the rest of the round. A module still in the running after the last bit has won. On the following acknowledge strobe, the winner returns an 8-bit vector: the programmed base nibble in the upper half and the serviced channel number in the lower half. The serviced channel's pending bit is then cleared.

Both the vector base and the arbitration identifier reset to zero. A zero identifier keeps the module out of every round. A zero base blocks all enabled requests and raises a configuration error flag, so a request can never produce a vector that falls into the bottom block of the vector table.

Top module: `irqv_responder`

## Requirements
- R1: After reset, the request line, the configuration error flag, the arbitration drive and the vector valid flag are all 0, and no channel is pending.
- R2: A 1 on bit n of the channel request input sets pending bit n; the request line is 1 while any pending channel has its enable bit set and the base is nonzero.
- R3: While the base is 0, the request line stays 0 and the configuration error flag is 1 whenever an enabled channel is pending; such a module drives nothing in an arbitration round.
- R4: A pending channel whose enable bit is 0 neither raises the request line nor is selected, but stays pending and becomes active once enabled.
- R5: A round starts on a one-cycle start pulse; in the next four cycles the module drives its identifier bits onto the arbitration line in the order bit 3, bit 2, bit 1, bit 0.
- R6: If the module drives 0 in a bit cycle while the line reads 1, it drives 0 in all remaining bit cycles, returns no vector on acknowledge, and keeps the channel pending.
- R7: With an identifier of 0 the module never drives the arbitration line and never returns a vector, even with requests pending.
- R8: After winning, the module asserts vector valid during the acknowledge cycle with vector = {base[3:0], channel[3:0]}; the vector output is 0 whenever valid is 0.
- R9: Among pending enabled channels, the lowest-numbered one is serviced.
- R10: At the end of the acknowledge cycle the serviced channel's pending bit is cleared and other pending bits are kept; a new request for the same channel in that cycle keeps it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_req_i | input | 16 | Per-channel request pulses |
| ch_en_i | input | 16 | Per-channel interrupt enable |
| base_wr_i | input | 1 | Write strobe for the vector base register |
| base_i | input | 4 | Vector base value to write |
| id_wr_i | input | 1 | Write strobe for the arbitration identifier |
| id_i | input | 4 | Arbitration identifier to write |
| arb_start_i | input | 1 | Start of an arbitration round |
| arb_bus_i | input | 1 | Wired-OR arbitration line as observed |
| arb_drive_o | output | 1 | This module's bit on the arbitration line |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| vec_o | output | 8 | Returned vector |
| vec_valid_o | output | 1 | Vector is being returned this cycle |
| irq_o | output | 1 | Enabled request pending |
| cfg_err_o | output | 1 | Enabled request blocked by a zero base |

## Verification
Rounds are run against opponent bit patterns that are all zero (an outright win) and that carry a 1 where the local identifier has a 0 (a loss part-way through), which tells a correct drop-out apart from a module that keeps driving or still answers the acknowledge. Requests arrive in scrambled channel order and mixed with disabled channels, so the vector sequence shows whether the lowest enabled channel is chosen and whether a disabled one is skipped yet retained. Zero base and zero identifier are each tried with requests pending, and a fresh request is posted in the very acknowledge cycle to separate clearing from setting.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_RUN  = 2'd1,
    ARB_WON  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/irqv_pending.sv
module irqv_pending #(
  parameter int NUM_CH = 16,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_i,
  input  logic              clr_valid_i,
  input  logic [CH_W-1:0]   clr_idx_i,
  output logic [NUM_CH-1:0] pend_o
);
  logic [NUM_CH-1:0] clr_mask;
  logic [NUM_CH-1:0] pend_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_clr
    assign clr_mask[g] = clr_valid_i && (clr_idx_i == CH_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_mask) | set_i;
  end

  assign pend_o = pend_q;

  AST_CLEAR_SERVICED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid_i && !set_i[clr_idx_i]) |=> !pend_o[$past(clr_idx_i)]); // R10
  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i))); // R2
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio #(
  parameter int NUM_CH = 16,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req_i,
  output logic              any_o,
  output logic [CH_W-1:0]   idx_o
);
  logic [NUM_CH-1:0] below;
  logic [NUM_CH-1:0] grant;

  assign below[0] = 1'b0;
  for (genvar g = 1; g < NUM_CH; g++) begin : g_below
    assign below[g] = below[g-1] | req_i[g-1];
  end
  assign grant = req_i & ~below;

  function automatic logic [CH_W-1:0] encode(input logic [NUM_CH-1:0] oh);
    logic [CH_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_CH; i++) if (oh[i]) r = r | CH_W'(i);
    return r;
  endfunction

  assign any_o = |req_i;
  assign idx_o = encode(grant);

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R9
  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> req_i[idx_o]); // R9
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int CH_W   = 4,
  parameter int BASE_W = 4,
  localparam int VEC_W = BASE_W + CH_W,
  localparam int IDX_W = (ID_W > 1) ? $clog2(ID_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              eligible_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              bus_i,
  input  logic              ack_i,
  output logic              drive_o,
  output logic              vec_valid_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              done_o,
  output logic [CH_W-1:0]   done_ch_o,
  output arb_state_e        state_o
);
  arb_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic              alive_q;
  logic              alive_nxt;
  logic              my_bit;
  logic              knocked_out;
  logic [ID_W-1:0]   id_q;
  logic [CH_W-1:0]   ch_q;
  logic [BASE_W-1:0] base_q;

  function automatic logic [VEC_W-1:0] make_vector(input logic [BASE_W-1:0] b,
                                                   input logic [CH_W-1:0] c);
    return {b, c};
  endfunction

  assign my_bit      = id_q[idx_q];
  assign knocked_out = !my_bit && bus_i;
  assign alive_nxt   = alive_q && !knocked_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      idx_q   <= '0;
      alive_q <= 1'b0;
      id_q    <= '0;
      ch_q    <= '0;
      base_q  <= '0;
    end else begin
      case (state_q)
        ARB_IDLE: if (start_i && eligible_i) begin
          state_q <= ARB_RUN;
          idx_q   <= IDX_W'(ID_W - 1);
          alive_q <= 1'b1;
          id_q    <= id_i;
          ch_q    <= ch_i;
          base_q  <= base_i;
        end
        ARB_RUN: begin
          alive_q <= alive_nxt;
          if (idx_q == '0) state_q <= alive_nxt ? ARB_WON : ARB_IDLE;
          else             idx_q   <= idx_q - 1'b1;
        end
        ARB_WON: if (ack_i) state_q <= ARB_IDLE;
        default: state_q <= ARB_IDLE;
      endcase
    end
  end

  assign drive_o     = (state_q == ARB_RUN) && alive_q && my_bit;
  assign vec_valid_o = (state_q == ARB_WON) && ack_i;
  assign vec_o       = vec_valid_o ? make_vector(base_q, ch_q) : '0;
  assign done_o      = vec_valid_o;
  assign done_ch_o   = ch_q;
  assign state_o     = state_q;

  AST_STAY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ARB_RUN && knocked_out && idx_q != '0) |=> !drive_o); // R6
  AST_LOSER_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ARB_RUN && !alive_q && idx_q == '0) |=> state_q == ARB_IDLE); // R6
  AST_VEC_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |=> !vec_valid_o); // R8
  AST_VEC_BASE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> vec_o[VEC_W-1:CH_W] != '0); // R8
endmodule

// File: rtl/irqv_responder.sv
module irqv_responder
  import irqv_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ID_W   = 4,
  parameter int BASE_W = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int VEC_W = BASE_W + CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_req_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic              base_wr_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              id_wr_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic              arb_start_i,
  input  logic              arb_bus_i,
  output logic              arb_drive_o,
  input  logic              ack_i,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_valid_o,
  output logic              irq_o,
  output logic              cfg_err_o
);
  logic [BASE_W-1:0] base_q;
  logic [ID_W-1:0]   id_q;
  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] enabled_pend;
  logic [NUM_CH-1:0] live_req;
  logic              base_set;
  logic              any_live;
  logic [CH_W-1:0]   sel_ch;
  logic              eligible;
  logic              done;
  logic [CH_W-1:0]   done_ch;
  arb_state_e        arb_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      id_q   <= '0;
    end else begin
      if (base_wr_i) base_q <= base_i;
      if (id_wr_i)   id_q   <= id_i;
    end
  end

  assign base_set     = (base_q != '0);
  assign enabled_pend = pend & ch_en_i;
  assign live_req     = base_set ? enabled_pend : '0;
  assign eligible     = any_live && (id_q != '0);

  irqv_pending #(.NUM_CH(NUM_CH)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(ch_req_i),
    .clr_valid_i(done), .clr_idx_i(done_ch), .pend_o(pend)
  );

  irqv_prio #(.NUM_CH(NUM_CH)) u_prio (
    .clk(clk), .rst_n(rst_n), .req_i(live_req), .any_o(any_live), .idx_o(sel_ch)
  );

  irqv_arbiter #(.ID_W(ID_W), .CH_W(CH_W), .BASE_W(BASE_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .start_i(arb_start_i), .eligible_i(eligible),
    .id_i(id_q), .ch_i(sel_ch), .base_i(base_q), .bus_i(arb_bus_i),
    .ack_i(ack_i), .drive_o(arb_drive_o), .vec_valid_o(vec_valid_o),
    .vec_o(vec_o), .done_o(done), .done_ch_o(done_ch), .state_o(arb_state)
  );

  assign irq_o     = any_live;
  assign cfg_err_o = !base_set && (enabled_pend != '0);

  AST_BASE_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !base_set |-> !irq_o); // R3
  AST_ZERO_ID_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (id_q == '0 && arb_state == ARB_IDLE) |=> arb_state == ARB_IDLE); // R7
  AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_state == ARB_IDLE && !irq_o) |=> arb_state == ARB_IDLE); // R4
endmodule

// File: tb/sim_irqv_responder.sv
module sim_irqv_responder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ch_req = '0;
  logic [15:0] ch_en = '0;
  logic        base_wr = 1'b0;
  logic [3:0]  base_v = '0;
  logic        id_wr = 1'b0;
  logic [3:0]  id_v = '0;
  logic        arb_start = 1'b0;
  logic        other_bit = 1'b0;
  logic        arb_bus;
  logic        arb_drive;
  logic        ack = 1'b0;
  logic [7:0]  vec;
  logic        vec_valid;
  logic        irq;
  logic        cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] cur_base = '0;
  logic [3:0] cur_id = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign arb_bus = arb_drive | other_bit;

  irqv_responder u0 (
    .clk(clk), .rst_n(rst_n), .ch_req_i(ch_req), .ch_en_i(ch_en),
    .base_wr_i(base_wr), .base_i(base_v), .id_wr_i(id_wr), .id_i(id_v),
    .arb_start_i(arb_start), .arb_bus_i(arb_bus), .arb_drive_o(arb_drive),
    .ack_i(ack), .vec_o(vec), .vec_valid_o(vec_valid), .irq_o(irq), .cfg_err_o(cfg_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic write_base(input logic [3:0] b);
    @(negedge clk); base_v = b; base_wr = 1'b1;
    @(negedge clk); base_wr = 1'b0; cur_base = b;
  endtask

  task automatic write_id(input logic [3:0] i);
    @(negedge clk); id_v = i; id_wr = 1'b1;
    @(negedge clk); id_wr = 1'b0; cur_id = i;
  endtask

  task automatic post(input logic [15:0] m);
    @(negedge clk); ch_req = m;
    @(negedge clk); ch_req = '0;
  endtask

  // One round: bench computes drive bits and outcome from its own model.
  task automatic round(input string tag, input logic elig, input logic [3:0] others,
                       input logic [3:0] exp_ch, input logic [15:0] req_at_ack);
    logic alive;
    logic exp_d;
    alive = 1'b1;
    @(negedge clk); arb_start = 1'b1;
    @(negedge clk); arb_start = 1'b0;
    for (int k = 3; k >= 0; k--) begin
      other_bit = others[k];
      #1;
      exp_d = elig & alive & cur_id[k];
      chk({tag, " drive bit (R5)"}, arb_drive, exp_d);
      if (!cur_id[k] && (exp_d | others[k])) alive = 1'b0;
      @(negedge clk);
    end
    other_bit = 1'b0;
    ack = 1'b1;
    ch_req = req_at_ack;
    #1;
    chk({tag, " vec_valid (R8)"}, vec_valid, elig & alive);
    chk({tag, " vec value (R8)"}, vec, (elig & alive) ? {cur_base, exp_ch} : 8'h00);
    @(negedge clk); ack = 1'b0; ch_req = '0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 irq", irq, 0);
    chk("R1 cfg_err", cfg_err, 0);
    chk("R1 drive", arb_drive, 0);
    chk("R1 vec_valid", vec_valid, 0);
    ch_en = 16'hFFFF;
    #1;
    chk("R1 no pending", cfg_err, 0);
  endtask

  task automatic t_base_zero();
    write_id(4'h5);
    post(16'h0008);
    #1;
    chk("R3 irq masked", irq, 0);
    chk("R3 cfg_err", cfg_err, 1);
    round("R3 base zero", 1'b0, 4'h0, 4'h0, '0);
  endtask

  task automatic t_id_zero();
    write_base(4'hA);
    write_id(4'h0);
    #1;
    chk("R2 irq raised", irq, 1);
    chk("R3 cfg_err cleared", cfg_err, 0);
    round("R7 id zero", 1'b0, 4'h0, 4'h0, '0);
    #1;
    chk("R7 still pending", irq, 1);
  endtask

  task automatic t_win();
    write_id(4'hB);
    round("R8 win ch3", 1'b1, 4'h0, 4'h3, '0);
    #1;
    chk("R10 cleared", irq, 0);
  endtask

  task automatic t_lowest();
    post(16'h1220);
    round("R9 first", 1'b1, 4'h0, 4'h5, '0);
    round("R9 second", 1'b1, 4'h0, 4'h9, '0);
    round("R9 third", 1'b1, 4'h0, 4'hC, '0);
    #1;
    chk("R10 all served", irq, 0);
  endtask

  task automatic t_disabled();
    ch_en = 16'hFFFB;
    post(16'h0084);
    round("R4 skip disabled", 1'b1, 4'h0, 4'h7, '0);
    #1;
    chk("R4 disabled no irq", irq, 0);
    chk("R4 disabled no cfg_err", cfg_err, 0);
    ch_en = 16'hFFFF;
    #1;
    chk("R4 enable reveals", irq, 1);
    round("R4 serve ch2", 1'b1, 4'h0, 4'h2, '0);
  endtask

  task automatic t_lose();
    post(16'h0002);
    round("R6 lose", 1'b1, 4'h4, 4'h1, '0);
    #1;
    chk("R6 kept pending", irq, 1);
    round("R6 retry win", 1'b1, 4'h0, 4'h1, '0);
  endtask

  task automatic t_same_cycle();
    post(16'h0010);
    round("R10 serve ch4", 1'b1, 4'h0, 4'h4, 16'h0010);
    #1;
    chk("R10 re-request kept", irq, 1);
    round("R10 serve ch4 again", 1'b1, 4'h0, 4'h4, '0);
    #1;
    chk("R10 finally clear", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_base_zero();
    t_id_zero();
    t_win();
    t_lowest();
    t_disabled();
    t_lose();
    t_same_cycle();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule